// File: doc/BRIEF.md
# Transmit Checksum Insertion Engine

This engine sits on the transmit side of a network interface. Software or a DMA engine first gives it a short side-band control record. It then sends the frame as a byte stream, in one or more pieces, with an end-of-packet flag on the final byte. The engine collects the whole frame in a local buffer. If the record asks for it, the engine computes a 16-bit ones'-complement sum over the tail of the frame, starting at a byte offset the record gives and running to the last byte, with a seed added in. It folds that sum, inverts it, and writes the result back into the frame at a second offset from the record. Only then does it stream the frame out and flag transmit completion.

No protocol headers are parsed. The caller decides where summing begins and where the result lands. This lets one datapath serve several transport protocols, with or without a pseudo-header contribution carried in the seed. While the frame is being summed or sent, both inputs are held off with backpressure. Three static configuration inputs decide whether transmission is allowed and whether mid-size tagged-length frames are allowed through.

Top module: `txcs_engine`

## Requirements
- R1: After a synchronous reset, m_valid and tx_done are low, s_ready and ctl_ready are high, and tx_bytes is zero.
- R2: When bit 0 of record word 0 is 0, each frame is sent out byte for byte and unchanged. m_last is set only on the final byte.
- R3: When bit 0 of record word 0 is 1, the engine forms a sum as follows. It starts from the seed (word 2 bits 15:0). To that it adds the frame bytes from the start offset (word 1 bits 31:16) through the last byte, taken as big-endian 16-bit pairs counted from the start offset. An odd trailing byte is the high half, with zero in the low half. The engine folds the carries twice and complements the result. It writes the high byte at the insert offset (word 1 bits 15:0) and the low byte one position later. Each of those two writes is skipped if its position is not inside the frame. A start offset at or beyond the frame length sums the seed alone.
- R4: A record takes effect only when exactly five 32-bit words arrive with ctl_last set on the fifth. Any record that ends after a different number of words is ignored, and the previously accepted record stays in force.
- R5: While cfg_tx_en is low, incoming data bytes are accepted and thrown away. Nothing is sent, and tx_bytes does not change.
- R6: A frame longer than DEPTH bytes is dropped in full and produces no output. The frame after it is handled normally. A frame of exactly DEPTH bytes is sent.
- R7: With cfg_jumbo_en and cfg_vlan_en both low, frames of 1519 to 1522 bytes are dropped. Setting either input lets such frames through, and a 1518-byte frame always passes.
- R8: Each sent frame produces exactly one single-cycle tx_done pulse, in the cycle after its last byte is taken. In that same cycle tx_bytes grows by the frame length. tx_bytes changes at no other time.
- R9: From the end of a frame's input until its last output byte is taken, s_ready and ctl_ready are low. While m_valid is high and m_ready is low, m_data and m_last hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_tx_en | input | 1 | Transmit allowed; data bytes are dropped when low |
| cfg_jumbo_en | input | 1 | Oversize frames allowed |
| cfg_vlan_en | input | 1 | Tagged-length frames (1519 to 1522 bytes) allowed |
| ctl_valid | input | 1 | Control word valid |
| ctl_ready | output | 1 | Control word accepted |
| ctl_data | input | 32 | Control record word |
| ctl_last | input | 1 | Final word of the control record |
| s_valid | input | 1 | Frame byte valid |
| s_ready | output | 1 | Frame byte accepted |
| s_data | input | 8 | Frame byte |
| s_last | input | 1 | End-of-packet on this byte |
| m_valid | output | 1 | Output byte valid |
| m_ready | input | 1 | Output byte taken |
| m_data | output | 8 | Output byte |
| m_last | output | 1 | Final byte of the output frame |
| tx_done | output | 1 | One-cycle pulse per frame sent |
| tx_bytes | output | 64 | Running total of bytes sent |

## Verification
The bench targets the sum's lane alignment. It uses odd frame lengths and odd start offsets. An engine that paired bytes from offset zero, or padded the trailing byte into the wrong half, would write a checksum whose two bytes are wrong or swapped. It places the insert offset on the last byte, and the start offset past the end of the frame. Here a missing bounds guard would corrupt the buffer past the frame, or sum stale data instead of the seed alone. Short and over-long control records must leave the previous record in place. Frames of exactly the buffer size, one byte over, and at both edges of the tagged-length window must be sent or dropped as R6 and R7 state. An off-by-one in either length compare shows up as a missing frame or an unexpected one. Output is throttled throughout, so a design that let m_data slip under backpressure, or accepted input during output, is caught byte by byte.

// File: rtl/txcs_pkg.sv
package txcs_pkg;

    localparam int CTL_WORDS   = 5;
    localparam int TAG_LEN_MIN = 1519;
    localparam int TAG_LEN_MAX = 1522;

    typedef enum logic [1:0] {
        ST_FILL,
        ST_SUM,
        ST_INSERT,
        ST_SEND
    } eng_state_e;

    typedef struct packed {
        logic        en;
        logic [15:0] start_off;
        logic [15:0] ins_off;
        logic [15:0] seed;
    } csum_rec_t;

    // Two carry folds followed by the ones'-complement.
    function automatic logic [15:0] fold_cpl(input logic [31:0] a);
        logic [16:0] t;
        logic [16:0] u;
        t = {1'b0, a[15:0]} + {1'b0, a[31:16]};
        u = {1'b0, t[15:0]} + {16'b0, t[16]};
        return ~u[15:0];
    endfunction

    function automatic logic in_tag_window(input logic [16:0] n);
        return (n >= 17'(TAG_LEN_MIN)) && (n <= 17'(TAG_LEN_MAX));
    endfunction

endpackage

// File: rtl/txcs_ctl_capture.sv
module txcs_ctl_capture
    import txcs_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        ctl_valid,
    input  logic        ctl_ready,
    input  logic [31:0] ctl_data,
    input  logic        ctl_last,
    output csum_rec_t   rec
);

    localparam int CW = $clog2(CTL_WORDS + 1);

    logic [CW-1:0] cnt;
    csum_rec_t     stage;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            stage <= '0;
            rec   <= '0;
        end else if (ctl_valid && ctl_ready) begin
            case (cnt)
                CW'(0): stage.en <= ctl_data[0];
                CW'(1): begin
                    stage.start_off <= ctl_data[31:16];
                    stage.ins_off   <= ctl_data[15:0];
                end
                CW'(2): stage.seed <= ctl_data[15:0];
                default: ;
            endcase
            if (ctl_last) begin
                cnt <= '0;
                if (cnt == CW'(CTL_WORDS - 1)) begin
                    rec <= stage;
                end
            end else if (cnt != CW'(CTL_WORDS)) begin
                cnt <= cnt + CW'(1);
            end
        end
    end

endmodule

// File: rtl/txcs_frame_buf.sv
module txcs_frame_buf #(
    parameter int DEPTH = 2048,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wa_en,
    input  logic [AW-1:0] wa_addr,
    input  logic [7:0]    wa_data,
    input  logic          wb_en,
    input  logic [AW-1:0] wb_addr,
    input  logic [7:0]    wb_data,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data
);

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wa_en) mem[wa_addr] <= wa_data;
        if (wb_en) mem[wb_addr] <= wb_data;
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/txcs_sum_acc.sv
module txcs_sum_acc (
    input  logic        clk,
    input  logic        rst,
    input  logic        load,
    input  logic [15:0] seed,
    input  logic        add,
    input  logic        hi_lane,
    input  logic [7:0]  din,
    output logic [31:0] acc
);

    logic [31:0] term;

    assign term = hi_lane ? {16'b0, din, 8'b0} : {24'b0, din};

    always_ff @(posedge clk) begin
        if (rst)       acc <= '0;
        else if (load) acc <= {16'b0, seed};
        else if (add)  acc <= acc + term;
    end

endmodule

// File: rtl/txcs_engine.sv
module txcs_engine
    import txcs_pkg::*;
#(
    parameter int DEPTH = 2048
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_tx_en,
    input  logic        cfg_jumbo_en,
    input  logic        cfg_vlan_en,
    input  logic        ctl_valid,
    output logic        ctl_ready,
    input  logic [31:0] ctl_data,
    input  logic        ctl_last,
    input  logic        s_valid,
    output logic        s_ready,
    input  logic [7:0]  s_data,
    input  logic        s_last,
    output logic        m_valid,
    input  logic        m_ready,
    output logic [7:0]  m_data,
    output logic        m_last,
    output logic        tx_done,
    output logic [63:0] tx_bytes
);

    localparam int AW = $clog2(DEPTH);
    localparam int LW = AW + 1;

    eng_state_e    state;
    csum_rec_t     rec;
    logic [LW-1:0] wr_pos, flen, ptr, new_len;
    logic          hi_lane, ovf;
    logic [31:0]   acc;
    logic [15:0]   csum;
    logic [7:0]    rd_data;
    logic          take, room, store, size_drop, start_past;
    logic [16:0]   ins17, len17;
    logic          wa_en, wb_en;
    logic [AW-1:0] wa_addr, wb_addr;
    logic [7:0]    wa_data;

    assign s_ready   = (state == ST_FILL);
    assign ctl_ready = (state == ST_FILL);

    assign take      = s_valid && s_ready && cfg_tx_en;
    assign room      = wr_pos < LW'(DEPTH);
    assign store     = take && room && !ovf;
    assign new_len   = wr_pos + LW'(1);
    assign size_drop = !cfg_jumbo_en && !cfg_vlan_en && in_tag_window(17'(new_len));
    assign start_past = {1'b0, rec.start_off} >= 17'(new_len);

    assign ins17 = {1'b0, rec.ins_off};
    assign len17 = 17'(flen);
    assign csum  = fold_cpl(acc);

    assign wa_en   = store || ((state == ST_INSERT) && (ins17 < len17));
    assign wa_addr = (state == ST_INSERT) ? rec.ins_off[AW-1:0] : wr_pos[AW-1:0];
    assign wa_data = (state == ST_INSERT) ? csum[15:8] : s_data;
    assign wb_en   = (state == ST_INSERT) && ((ins17 + 17'd1) < len17);
    assign wb_addr = rec.ins_off[AW-1:0] + AW'(1);

    assign m_valid = (state == ST_SEND);
    assign m_data  = rd_data;
    assign m_last  = (ptr == flen - LW'(1));

    txcs_ctl_capture u_ctl (
        .clk       (clk),
        .rst       (rst),
        .ctl_valid (ctl_valid),
        .ctl_ready (ctl_ready),
        .ctl_data  (ctl_data),
        .ctl_last  (ctl_last),
        .rec       (rec)
    );

    txcs_frame_buf #(.DEPTH(DEPTH), .AW(AW)) u_buf (
        .clk     (clk),
        .wa_en   (wa_en),
        .wa_addr (wa_addr),
        .wa_data (wa_data),
        .wb_en   (wb_en),
        .wb_addr (wb_addr),
        .wb_data (csum[7:0]),
        .rd_addr (ptr[AW-1:0]),
        .rd_data (rd_data)
    );

    txcs_sum_acc u_acc (
        .clk     (clk),
        .rst     (rst),
        .load    (store && s_last),
        .seed    (rec.seed),
        .add     ((state == ST_SUM) && (ptr < flen)),
        .hi_lane (hi_lane),
        .din     (rd_data),
        .acc     (acc)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_FILL;
            wr_pos   <= '0;
            flen     <= '0;
            ptr      <= '0;
            hi_lane  <= 1'b1;
            ovf      <= 1'b0;
            tx_done  <= 1'b0;
            tx_bytes <= '0;
        end else begin
            tx_done <= 1'b0;
            case (state)
                ST_FILL: begin
                    if (take) begin
                        if (!room || ovf) begin
                            if (s_last) begin
                                ovf    <= 1'b0;
                                wr_pos <= '0;
                            end else begin
                                ovf <= 1'b1;
                            end
                        end else if (!s_last) begin
                            wr_pos <= new_len;
                        end else begin
                            wr_pos <= '0;
                            if (!size_drop) begin
                                flen    <= new_len;
                                hi_lane <= 1'b1;
                                if (!rec.en) begin
                                    state <= ST_SEND;
                                    ptr   <= '0;
                                end else if (start_past) begin
                                    state <= ST_INSERT;
                                end else begin
                                    state <= ST_SUM;
                                    ptr   <= LW'(rec.start_off);
                                end
                            end
                        end
                    end
                end
                ST_SUM: begin
                    if (ptr < flen) begin
                        ptr     <= ptr + LW'(1);
                        hi_lane <= !hi_lane;
                    end else begin
                        state <= ST_INSERT;
                    end
                end
                ST_INSERT: begin
                    state <= ST_SEND;
                    ptr   <= '0;
                end
                ST_SEND: begin
                    if (m_ready) begin
                        if (m_last) begin
                            state    <= ST_FILL;
                            tx_done  <= 1'b1;
                            tx_bytes <= tx_bytes + 64'(flen);
                        end else begin
                            ptr <= ptr + LW'(1);
                        end
                    end
                end
                default: state <= ST_FILL;
            endcase
        end
    end

endmodule

// File: rtl/txcs_engine_chk.sv
module txcs_engine_chk (
    input logic        clk,
    input logic        rst,
    input logic        s_ready,
    input logic        ctl_ready,
    input logic        m_valid,
    input logic        m_ready,
    input logic [7:0]  m_data,
    input logic        m_last,
    input logic        tx_done,
    input logic [63:0] tx_bytes
);

    // R9
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_last)));

    // R9
    no_accept_while_send_chk: assert property (@(posedge clk) disable iff (rst)
        m_valid |-> (!s_ready && !ctl_ready));

    // R8
    done_after_last_chk: assert property (@(posedge clk) disable iff (rst)
        tx_done |-> $past(m_valid && m_ready && m_last));

    // R8
    count_moves_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_bytes != $past(tx_bytes)) |-> tx_done);

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        tx_done |=> !tx_done);

endmodule

bind txcs_engine txcs_engine_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .s_ready   (s_ready),
    .ctl_ready (ctl_ready),
    .m_valid   (m_valid),
    .m_ready   (m_ready),
    .m_data    (m_data),
    .m_last    (m_last),
    .tx_done   (tx_done),
    .tx_bytes  (tx_bytes)
);

// File: tb/txcs_engine_bench.sv
module txcs_engine_bench;

    localparam int DEPTH = 2048;

    typedef logic [7:0] bytes_t[];
    typedef struct {
        logic [7:0] d;
        logic       l;
        int         req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_tx_en = 1'b1, cfg_jumbo_en = 1'b0, cfg_vlan_en = 1'b0;
    logic        ctl_valid = 1'b0, ctl_last = 1'b0;
    logic [31:0] ctl_data = '0;
    logic        ctl_ready;
    logic        s_valid = 1'b0, s_last = 1'b0;
    logic [7:0]  s_data = '0;
    logic        s_ready;
    logic        m_valid, m_last, tx_done;
    logic        m_ready = 1'b0;
    logic [7:0]  m_data;
    logic [63:0] tx_bytes;

    always #2 clk = ~clk;

    txcs_engine #(.DEPTH(DEPTH)) u_txcs_engine (
        .clk(clk), .rst(rst), .cfg_tx_en(cfg_tx_en), .cfg_jumbo_en(cfg_jumbo_en),
        .cfg_vlan_en(cfg_vlan_en), .ctl_valid(ctl_valid), .ctl_ready(ctl_ready),
        .ctl_data(ctl_data), .ctl_last(ctl_last), .s_valid(s_valid), .s_ready(s_ready),
        .s_data(s_data), .s_last(s_last), .m_valid(m_valid), .m_ready(m_ready),
        .m_data(m_data), .m_last(m_last), .tx_done(tx_done), .tx_bytes(tx_bytes)
    );

    exp_t   exp_q[$];
    int     tests = 0, fails = 0;
    int     done_seen = 0, exp_done = 0;
    longint exp_bytes = 0;
    bit     finished = 0;

    bit          cur_en = 0;
    int          cur_start = 0, cur_ins = 0, cur_seed = 0;

    // Throttled output acceptance, updated at the rising edge.
    logic [7:0] lf = 8'h5a;
    always @(posedge clk) begin
        lf      <= {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
        m_ready <= (lf[1:0] != 2'b00);
    end

    // Monitor: pops the scoreboard on every output handshake (R2, R3, R9).
    always @(negedge clk) begin
        if (!rst) begin
            if (tx_done) done_seen++;
            if (m_valid) begin
                tests++;
                if (s_ready || ctl_ready) begin
                    fails++;
                    $display("FAIL R9: inputs ready during output, actual s_ready=%0b ctl_ready=%0b expected 0/0",
                             s_ready, ctl_ready);
                end
                if (m_ready) begin
                    tests++;
                    if (exp_q.size() == 0) begin
                        fails++;
                        $display("FAIL R5/R6/R7: unexpected output byte actual %02h expected none", m_data);
                    end else begin
                        exp_t e;
                        e = exp_q.pop_front();
                        if (m_data !== e.d || m_last !== e.l) begin
                            fails++;
                            $display("FAIL R%0d: output byte actual %02h last %0b expected %02h last %0b",
                                     e.req, m_data, m_last, e.d, e.l);
                        end
                    end
                end
            end
        end
    end

    function automatic bytes_t mk_frame(input int len, input int base);
        bytes_t f = new[len];
        for (int i = 0; i < len; i++) f[i] = 8'((i * 7 + base) ^ (i >> 3));
        return f;
    endfunction

    task automatic send_ctl(input bit en, input int start, input int ins, input int seed, input int nwords);
        for (int i = 0; i < nwords; i++) begin
            ctl_valid = 1'b1;
            ctl_last  = (i == nwords - 1);
            case (i)
                0: ctl_data = {31'h2a5a5a5a, en};
                1: ctl_data = {16'(start), 16'(ins)};
                2: ctl_data = {16'hbeef, 16'(seed)};
                default: ctl_data = 32'h1234_0000 + i;
            endcase
            while (!ctl_ready) @(negedge clk);
            @(negedge clk);
        end
        ctl_valid = 1'b0;
        ctl_last  = 1'b0;
        if (nwords == 5) begin
            cur_en = en; cur_start = start; cur_ins = ins; cur_seed = seed;
        end
    endtask

    task automatic send_frame(input bytes_t fr, input bit expect_out, input int req);
        int len = fr.size();
        if (expect_out) begin
            bytes_t ex = new[len](fr);
            if (cur_en) begin
                longint acc = cur_seed;
                longint t;
                logic [15:0] c;
                for (int i = cur_start; i < len; i++)
                    acc += (((i - cur_start) % 2) == 0) ? (longint'(fr[i]) << 8) : longint'(fr[i]);
                t = (acc & 'hffff) + (acc >> 16);
                t = (t & 'hffff) + (t >> 16);
                c = ~16'(t);
                if (cur_ins < len)     ex[cur_ins]     = c[15:8];
                if (cur_ins + 1 < len) ex[cur_ins + 1] = c[7:0];
            end
            for (int i = 0; i < len; i++) exp_q.push_back('{ex[i], i == len - 1, req});
            exp_bytes += len;
            exp_done++;
        end
        for (int i = 0; i < len; i++) begin
            s_valid = 1'b1;
            s_data  = fr[i];
            s_last  = (i == len - 1);
            while (!s_ready) @(negedge clk);
            @(negedge clk);
        end
        s_valid = 1'b0;
        s_last  = 1'b0;
    endtask

    task automatic settle(input int req);
        repeat (4) @(negedge clk);
        while (exp_q.size() != 0 || m_valid || !s_ready) @(negedge clk);
        repeat (4) @(negedge clk);
        tests++;
        if (tx_bytes !== 64'(exp_bytes)) begin
            fails++;
            $display("FAIL R%0d/R8: tx_bytes actual %0d expected %0d", req, tx_bytes, exp_bytes);
        end
        tests++;
        if (done_seen != exp_done) begin
            fails++;
            $display("FAIL R%0d/R8: tx_done pulses actual %0d expected %0d", req, done_seen, exp_done);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            fails++;
            $display("FAIL watchdog: run did not finish, actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        tests++;
        if (m_valid !== 1'b0 || tx_done !== 1'b0 || s_ready !== 1'b1 || ctl_ready !== 1'b1 || tx_bytes !== 64'd0) begin
            fails++;
            $display("FAIL R1: reset outputs actual v=%0b d=%0b sr=%0b cr=%0b n=%0d expected 0 0 1 1 0",
                     m_valid, tx_done, s_ready, ctl_ready, tx_bytes);
        end

        // R2: passthrough with insertion off
        send_ctl(0, 3, 4, 16'h1111, 5);
        send_frame(mk_frame(20, 1), 1, 2);
        settle(2);

        // R3: even length, odd length, odd start, start past end, insert on last byte
        send_ctl(1, 14, 24, 16'h1234, 5);
        send_frame(mk_frame(40, 9), 1, 3);
        settle(3);
        send_frame(mk_frame(41, 17), 1, 3);
        settle(3);
        send_ctl(1, 15, 16, 16'hffff, 5);
        send_frame(mk_frame(33, 200), 1, 3);
        settle(3);
        send_ctl(1, 100, 2, 16'h0f0f, 5);
        send_frame(mk_frame(30, 5), 1, 3);
        settle(3);
        send_ctl(1, 0, 29, 16'h0001, 5);
        send_frame(mk_frame(30, 77), 1, 3);
        settle(3);

        // R4: short and long records leave the previous one in force
        send_ctl(0, 0, 0, 0, 5);
        send_ctl(1, 2, 4, 16'h5555, 4);
        send_frame(mk_frame(18, 33), 1, 4);
        settle(4);
        send_ctl(1, 2, 4, 16'h5555, 6);
        send_frame(mk_frame(18, 44), 1, 4);
        settle(4);

        // R5: transmit disabled drops data
        cfg_tx_en = 1'b0;
        send_frame(mk_frame(10, 3), 0, 5);
        settle(5);
        cfg_tx_en = 1'b1;
        send_ctl(1, 6, 8, 16'h00ff, 5);
        send_frame(mk_frame(12, 8), 1, 5);
        settle(5);

        // R6: buffer overflow drops frame; exact fit passes
        send_frame(mk_frame(DEPTH + 5, 2), 0, 6);
        settle(6);
        send_frame(mk_frame(16, 90), 1, 6);
        settle(6);
        send_ctl(0, 0, 0, 0, 5);
        send_frame(mk_frame(DEPTH, 4), 1, 6);
        settle(6);

        // R7: tagged-length window
        send_frame(mk_frame(1519, 6), 0, 7);
        settle(7);
        send_frame(mk_frame(1522, 7), 0, 7);
        settle(7);
        send_frame(mk_frame(1518, 8), 1, 7);
        settle(7);
        cfg_vlan_en = 1'b1;
        send_frame(mk_frame(1520, 9), 1, 7);
        settle(7);
        cfg_vlan_en  = 1'b0;
        cfg_jumbo_en = 1'b1;
        send_frame(mk_frame(1521, 10), 1, 7);
        settle(7);
        cfg_jumbo_en = 1'b0;

        // R8: final totals (also checked after every frame in settle)
        settle(8);

        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule